// File: doc/BRIEF.md
# Receive Symbol Monitor with Latching Status

This block sits beside a 100 Mb/s receive path and inspects each decoded 5-bit code group while a frame is being received. It raises an error flag when a Halt code group shows up inside a frame. It raises a second error flag when two Idle code groups arrive back to back inside a frame, which marks a frame that ended early. Both flags latch high. Once set, they hold until management software reads the status word or the block is reset, so a short event is never missed between two polls.

The same status word also carries two link-level bits. One shows that auto-negotiation has finished. The other is a live copy of the receive signal-present input. When the port runs at 10 Mb/s, the two error flags have no meaning: detection stops, any stored flag is dropped, and both bits read zero. The serial management framing, the 4B/5B decoder and the analog signal detector are outside this block.

Top module: `rx_symbol_monitor`

## Requirements
- R1: After a synchronous reset, the Halt flag (bit 6) and the early-end flag (bit 5) of `stat_word` read zero.
- R2: A code group 5'b00100 with `cg_valid` high, `rx_in_pkt` high and `speed_100` high sets bit 6 of `stat_word` from the next cycle. The same code outside a frame does not set it.
- R3: Two valid Idle code groups (5'b11111) in a row inside a frame at 100 Mb/s set bit 5 from the cycle after the second one. Cycles with `cg_valid` low do not break the pair. A valid non-Idle code group, or `rx_in_pkt` going low, restarts the count. Idles outside a frame never set the flag.
- R4: A set flag stays at one, whatever the inputs do, until a read or a reset (or 10 Mb/s mode, R6).
- R5: In a cycle with `stat_rd` high, `stat_word` shows the flags as they stood, and the flags read zero from the next cycle. If a setting event falls in the same cycle as the read, that flag stays at one afterwards.
- R6: While `speed_100` is low (10 Mb/s), bits 6 and 5 read zero from the next cycle on, and no code group sets them.
- R7: Bit 4 of `stat_word` equals `an_enable AND an_done`. It reads zero whenever `an_enable` is low.
- R8: Bit 3 of `stat_word` follows `sig_present` in the same cycle, with no latching.
- R9: Bits 15..7 and 2..0 of `stat_word` always read zero.
- R10: Code groups presented while `cg_valid` is low have no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| cg_valid | input | 1 | Code group strobe |
| cg_code | input | 5 | Decoded 5-bit code group |
| rx_in_pkt | input | 1 | High while a frame is being received |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| an_enable | input | 1 | Auto-negotiation enable control |
| an_done | input | 1 | Auto-negotiation finished indication |
| sig_present | input | 1 | Receive signal-present level |
| stat_rd | input | 1 | Status read strobe; clears latched flags |
| stat_word | output | 16 | Status word |

## Verification
A stuck or wrongly cleared latch shows at bit 6 or bit 5 of `stat_word` one cycle after the event or read that should have changed it. The bench compares every cycle, so the fault appears right away. A faulty Idle tracker shows up as a flag that sets after an Idle pair broken by data or by the end of a frame, or that fails to set after a true pair; either one is visible on the next cycle. Read and event collisions, and mode switches, are driven on purpose so that a lost event or a stale flag appears in the cycle straight after.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;
  localparam int CG_W      = 5;
  localparam int STAT_W    = 16;
  localparam logic [CG_W-1:0] CG_HALT = 5'b00100;
  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam int POS_HALT  = 6;
  localparam int POS_PEND  = 5;
  localparam int POS_ANOK  = 4;
  localparam int POS_SIG   = 3;
  localparam int NFLAG     = 2;
  typedef enum int {FLAG_HALT = 0, FLAG_PEND = 1} flag_e;
endpackage

// File: rtl/rxmon_detect.sv
module rxmon_detect
  import rxmon_pkg::*;
#(
  parameter int W = CG_W,
  parameter logic [W-1:0] HALT_C = CG_HALT,
  parameter logic [W-1:0] IDLE_C = CG_IDLE
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         cg_valid,
  input  logic [W-1:0] cg_code,
  input  logic         rx_in_pkt,
  input  logic         speed_100,
  output logic         hit_halt,
  output logic         hit_pend
);
  logic armed;
  logic code_idle;
  logic prev_idle_q;

  always_comb begin
    armed     = speed_100 & rx_in_pkt;
    code_idle = (cg_code == IDLE_C);
    hit_halt  = cg_valid & armed & (cg_code == HALT_C);
    hit_pend  = cg_valid & armed & code_idle & prev_idle_q;
  end

  // Tracks whether the last valid code group in this frame was Idle.
  always_ff @(posedge clk) begin
    if (rst || !armed)
      prev_idle_q <= 1'b0;
    else if (cg_valid)
      prev_idle_q <= code_idle;
  end
endmodule

// File: rtl/rxmon_latch.sv
module rxmon_latch #(
  parameter int N = 2
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         drop_all,
  input  logic         rd,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || drop_all)
        q[i] <= 1'b0;
      else if (set[i])
        q[i] <= 1'b1;
      else if (rd)
        q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxmon_pack.sv
module rxmon_pack
  import rxmon_pkg::*;
#(
  parameter int SW = STAT_W
)(
  input  logic [NFLAG-1:0] flags,
  input  logic             an_ok,
  input  logic             sig,
  output logic [SW-1:0]    word
);
  always_comb begin
    word           = '0;
    word[POS_HALT] = flags[FLAG_HALT];
    word[POS_PEND] = flags[FLAG_PEND];
    word[POS_ANOK] = an_ok;
    word[POS_SIG]  = sig;
  end
endmodule

// File: rtl/rx_symbol_monitor.sv
module rx_symbol_monitor
  import rxmon_pkg::*;
#(
  parameter int CGW = CG_W,
  parameter int SW  = STAT_W
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           cg_valid,
  input  logic [CGW-1:0] cg_code,
  input  logic           rx_in_pkt,
  input  logic           speed_100,
  input  logic           an_enable,
  input  logic           an_done,
  input  logic           sig_present,
  input  logic           stat_rd,
  output logic [SW-1:0]  stat_word
);
  logic             hit_halt;
  logic             hit_pend;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flag_q;

  rxmon_detect #(.W(CGW)) u_det (
    .clk(clk), .rst(rst), .cg_valid(cg_valid), .cg_code(cg_code),
    .rx_in_pkt(rx_in_pkt), .speed_100(speed_100),
    .hit_halt(hit_halt), .hit_pend(hit_pend)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_HALT] = hit_halt;
    set_vec[FLAG_PEND] = hit_pend;
  end

  rxmon_latch #(.N(NFLAG)) u_lat (
    .clk(clk), .rst(rst), .drop_all(!speed_100), .rd(stat_rd),
    .set(set_vec), .q(flag_q)
  );

  rxmon_pack #(.SW(SW)) u_pack (
    .flags(flag_q), .an_ok(an_enable & an_done), .sig(sig_present),
    .word(stat_word)
  );
endmodule

// File: rtl/rxmon_checker.sv
module rxmon_checker
  import rxmon_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        cg_valid,
  input logic [4:0]  cg_code,
  input logic        rx_in_pkt,
  input logic        speed_100,
  input logic        an_enable,
  input logic        an_done,
  input logic        sig_present,
  input logic        stat_rd,
  input logic [15:0] stat_word
);
  logic ev_halt, ev_idle;
  assign ev_halt = cg_valid && rx_in_pkt && speed_100 && cg_code == 5'b00100;
  assign ev_idle = cg_valid && rx_in_pkt && speed_100 && cg_code == 5'b11111;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (stat_word[6] == 1'b0 && stat_word[5] == 1'b0));
  a_r2_halt_sets: assert property (@(posedge clk) disable iff (rst)
    ev_halt |=> stat_word[6]);
  a_r3_idle_pair: assert property (@(posedge clk) disable iff (rst)
    (ev_idle && $past(ev_idle) && $past(!rst)) |=> stat_word[5]);
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (stat_word[6] && !stat_rd && speed_100) |=> stat_word[6]);
  a_r4_pend_holds: assert property (@(posedge clk) disable iff (rst)
    (stat_word[5] && !stat_rd && speed_100) |=> stat_word[5]);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !ev_halt) |=> !stat_word[6]);
  a_r6_slow_mode: assert property (@(posedge clk) disable iff (rst)
    !speed_100 |=> (!stat_word[6] && !stat_word[5]));
  a_r7_an_off: assert property (@(posedge clk) disable iff (rst)
    !an_enable |-> !stat_word[4]);
  a_r8_sig_live: assert property (@(posedge clk) disable iff (rst)
    stat_word[3] == sig_present);
  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (stat_word & 16'hFF87) == 16'h0000);
endmodule

bind rx_symbol_monitor rxmon_checker u_chk (
  .clk(clk), .rst(rst), .cg_valid(cg_valid), .cg_code(cg_code),
  .rx_in_pkt(rx_in_pkt), .speed_100(speed_100), .an_enable(an_enable),
  .an_done(an_done), .sig_present(sig_present), .stat_rd(stat_rd),
  .stat_word(stat_word)
);

// File: tb/rx_symbol_monitor_test.sv
`timescale 1ns/1ps
module rx_symbol_monitor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cg_valid = 1'b0;
  logic [4:0]  cg_code = 5'b0;
  logic        rx_in_pkt = 1'b0;
  logic        speed_100 = 1'b1;
  logic        an_enable = 1'b0;
  logic        an_done = 1'b0;
  logic        sig_present = 1'b0;
  logic        stat_rd = 1'b0;
  logic [15:0] stat_word;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  // model state
  bit m_halt, m_pend, m_prev;

  localparam logic [4:0] HALT = 5'b00100;
  localparam logic [4:0] IDLE = 5'b11111;
  localparam logic [4:0] DATA = 5'b01010;

  rx_symbol_monitor uut (
    .clk(clk), .rst(rst), .cg_valid(cg_valid), .cg_code(cg_code),
    .rx_in_pkt(rx_in_pkt), .speed_100(speed_100), .an_enable(an_enable),
    .an_done(an_done), .sig_present(sig_present), .stat_rd(stat_rd),
    .stat_word(stat_word)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] expect_word();
    logic [15:0] w = 16'h0;
    w[6] = m_halt;
    w[5] = m_pend;
    w[4] = an_enable & an_done;
    w[3] = sig_present;
    return w;
  endfunction

  // Driver: push expectation for this cycle, then advance the model.
  task automatic cyc(input string tag);
    bit armed, hev, iev, pev;
    exp_q.push_back(expect_word());
    tag_q.push_back(tag);
    armed = speed_100 && rx_in_pkt;
    hev = cg_valid && armed && cg_code == HALT;
    iev = cg_valid && armed && cg_code == IDLE;
    pev = iev && m_prev;
    @(posedge clk);
    if (!speed_100) begin
      m_halt = 0; m_pend = 0;
    end else begin
      m_halt = hev ? 1'b1 : (stat_rd ? 1'b0 : m_halt);
      m_pend = pev ? 1'b1 : (stat_rd ? 1'b0 : m_pend);
    end
    if (!armed) m_prev = 0;
    else if (cg_valid) m_prev = (cg_code == IDLE);
    @(negedge clk);
  endtask

  task automatic grp(input logic v, input logic [4:0] c, input string tag);
    cg_valid = v; cg_code = c;
    cyc(tag);
    cg_valid = 1'b0; cg_code = DATA;
  endtask

  task automatic rd(input string tag);
    stat_rd = 1'b1;
    cyc(tag);
    stat_rd = 1'b0;
  endtask

  // Monitor: pop and compare away from the clock edge.
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (stat_word !== e) begin
        miscompares++;
        $display("FAIL %s: stat_word=%h expected=%h", t, stat_word, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_halt = 0; m_pend = 0; m_prev = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc("R1 reset state");
    cyc("R9 reserved bits zero");

    // R7 auto-negotiation complete
    an_enable = 0; an_done = 1; cyc("R7 enable low");
    an_enable = 1; an_done = 0; cyc("R7 not done");
    an_enable = 1; an_done = 1; cyc("R7 complete");
    an_enable = 0; cyc("R7 enable dropped");
    an_enable = 1;

    // R8 live signal detect
    sig_present = 1; cyc("R8 signal on");
    sig_present = 0; cyc("R8 signal off");
    sig_present = 1; cyc("R8 signal on again");

    // R2 halt outside frame, R10 halt without strobe
    rx_in_pkt = 0; grp(1, HALT, "R2 halt outside frame"); cyc("R2 no set outside");
    rx_in_pkt = 1; grp(0, HALT, "R10 halt unstrobed"); cyc("R10 no set unstrobed");
    grp(1, HALT, "R2 halt in frame"); cyc("R2 halt latched");
    // R4 holds
    grp(1, DATA, "R4 hold data"); rx_in_pkt = 0; cyc("R4 hold after frame");
    repeat (3) cyc("R4 hold idle cycles");
    // R5 read returns old, then clears
    rd("R5 read shows set"); cyc("R5 cleared after read");
    // R5 event during read
    rx_in_pkt = 1;
    cg_valid = 1; cg_code = HALT; rd("R5 read with event");
    cg_valid = 0; cyc("R5 event kept"); rd("R5 second read"); cyc("R5 cleared");

    // R3 idle tracker
    grp(1, IDLE, "R3 idle one"); grp(1, DATA, "R3 broken by data");
    grp(1, IDLE, "R3 idle after data"); cyc("R3 no set yet");
    grp(1, DATA, "R3 data");
    grp(1, IDLE, "R3 first idle"); rx_in_pkt = 0; cyc("R3 frame drop");
    rx_in_pkt = 1; grp(1, IDLE, "R3 idle new frame"); cyc("R3 no set across frames");
    grp(1, DATA, "R3 data");
    rx_in_pkt = 0; grp(1, IDLE, "R3 idle outside"); grp(1, IDLE, "R3 idle outside 2");
    cyc("R3 no set outside frame");
    rx_in_pkt = 1; grp(1, IDLE, "R3 pair first"); grp(0, DATA, "R10 gap unstrobed");
    grp(1, IDLE, "R3 pair second"); cyc("R3 pair latched");
    rd("R5 read pend"); cyc("R5 pend cleared");
    grp(1, IDLE, "R3 idle"); grp(1, IDLE, "R3 pair direct"); cyc("R3 set direct");

    // R6 slow mode
    grp(1, HALT, "R6 halt before switch"); cyc("R6 both set");
    speed_100 = 0; cyc("R6 switch cycle"); cyc("R6 flags dropped");
    grp(1, HALT, "R6 halt ignored"); grp(1, IDLE, "R6 idle"); grp(1, IDLE, "R6 idle2");
    cyc("R6 still zero");
    speed_100 = 1; cyc("R6 back to 100"); rx_in_pkt = 0;
    cyc("R9 final reserved check");

    // R1 reset after set
    rx_in_pkt = 1; grp(1, HALT, "R1 set before reset"); cyc("R1 set");
    rst = 1; @(posedge clk); @(posedge clk); @(negedge clk); rst = 0;
    m_halt = 0; m_pend = 0; m_prev = 0;
    cyc("R1 cleared by reset");

    @(negedge clk); #5;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule